// File: doc/BRIEF.md
# Exception Entry and Status Control

This block decides, one instruction at a time, whether the current instruction of a MIPS-like core enters an exception, and it holds the coprocessor-0 state that goes with that decision. It sees the instruction word, the address of that instruction and the address the pipeline will fetch next, a TLB-miss request, the current process ID and the value of the instruction's rt operand. When an exception is taken, the block acts in the same cycle. It redirects the fetch to a fixed vector, squashes the following instruction and cancels the register write of the excepting instruction. On the next clock edge it records a return address and leaves user mode.

The saved return address carries two flags in its two low bits. Bit 1 marks an instruction that sat in a branch delay slot. Bit 0 marks a trap instruction, either a system call or a breakpoint. The block also executes coprocessor-0 moves. A move-from returns either the status bit or the saved return address. A move-to updates the status bit and may enter user mode, but only for a nonzero process ID.

Top module: `exc_ctrl`

## Requirements
- R1: Synchronous active-low reset clears `status`, `user_mode` and `epc` to zero.
- R2: With `instr_valid` high, an exception is taken when the instruction is a trap or `tlb_miss` is high. A trap is opcode bits 31:26 = 0 with function bits 5:0 = 0x0C (system call) or 0x0D (breakpoint). In that same cycle `redirect_valid`, `squash_next` and `rt_write_cancel` are 1 and `redirect_pc` is 0x3C. Otherwise all three flags are 0.
- R3: One cycle after an exception, `epc[31:2]` equals bits 31:2 of the excepting `pc` plus 4.
- R4: `epc[1]` is set after an exception exactly when `pc_next` differed from `pc` plus 4, which marks a branch delay slot.
- R5: `epc[0]` is set after an exception only when a trap caused it. A TLB miss takes priority over a trap in the same cycle, so `epc[0]` is then 0.
- R6: Taking an exception clears `user_mode` and leaves `status` unchanged.
- R7: A move-from (opcode 0x10, bit 23 = 0) drives `cp0_rdata` in the same cycle. If the register number in bits 15:11 is 12, `cp0_rdata` is the status bit, zero-extended. Any other register number gives `epc`. Every other instruction drives `cp0_rdata` to 0.
- R8: A move-to (opcode 0x10, bit 23 = 1) loads `status` from bit 0 of `rt_val` on the next edge.
- R9: A move-to sets `user_mode` when bit 1 of `rt_val` is 1 and `pid` is nonzero. With `pid` zero, or with that bit 0, `user_mode` keeps its value.
- R10: With `instr_valid` low, no exception is taken and no register changes, whatever the instruction and `tlb_miss` are.
- R11: A move-to that coincides with a TLB miss is not performed: the exception is taken and `status` keeps its value.
- R12: A valid instruction that is neither a trap nor a coprocessor-0 move, with no TLB miss, changes no state and takes no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the presented instruction |
| pc_next | input | XLEN | Address the pipeline will fetch next |
| tlb_miss | input | 1 | Translation miss for this instruction |
| pid | input | PID_W | Current process ID |
| rt_val | input | XLEN | Value of the rt operand |
| redirect_valid | output | 1 | Exception taken, fetch redirected |
| redirect_pc | output | XLEN | Exception vector address |
| squash_next | output | 1 | Discard the following instruction |
| rt_write_cancel | output | 1 | Cancel the register write of this instruction |
| cp0_rdata | output | XLEN | Result of a coprocessor-0 move-from |
| status | output | 1 | Status bit |
| user_mode | output | 1 | User-mode flag |
| epc | output | XLEN | Saved return address with flags |

## Verification
A wrong decode or priority choice appears in the same cycle on `redirect_valid` and its companion flags. A wrong captured return address or flag appears one cycle later on `epc`, and it can also be read back through a move-from. A `user_mode` or `status` register that takes a write it should refuse shows on its output on the next edge. The tests therefore drive each stimulus and sample the combinational flags within that cycle. They sample the registered state after the following edge, before any further instruction is presented.

// File: rtl/exc_pkg.sv
// Package: shared encodings and types for the exception entry block.
// Assumes a 32-bit instruction word with the opcode in bits 31:26.
package exc_pkg;

    localparam int INSTR_W = 32;

    localparam logic [5:0] OP_SPECIAL = 6'h00;
    localparam logic [5:0] OP_COP0    = 6'h10;
    localparam logic [5:0] FN_SYSCALL = 6'h0C;
    localparam logic [5:0] FN_BREAK   = 6'h0D;

    // Selected exception source for the current instruction
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_TLB  = 2'd1,
        CAUSE_TRAP = 2'd2
    } cause_e;

    // Decoded coprocessor-0 move
    typedef struct packed {
        logic       rd_en;
        logic       wr_en;
        logic [4:0] sel;
    } cp0_op_t;

endpackage

// File: rtl/exc_decode.sv
// Module: exc_decode
// Decodes the trap instructions and the coprocessor-0 moves from an
// instruction word. All outputs are gated by instr_valid.
// Assumes opcode bits 31:26, function bits 5:0, direction bit 23, rd 15:11.
module exc_decode
    import exc_pkg::*;
(
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    output logic               is_trap,
    output cp0_op_t            cp0_op
);

    logic [5:0] opcode;
    logic [5:0] func;
    logic       unused_fields;

    assign opcode = instr[31:26];
    assign func   = instr[5:0];
    assign unused_fields = ^{instr[25:24], instr[22:16], instr[10:6]};

    // Recognise system call and breakpoint in the special opcode group
    always_comb begin
        is_trap = instr_valid && (opcode == OP_SPECIAL) &&
                  ((func == FN_SYSCALL) || (func == FN_BREAK));
    end

    // Recognise coprocessor-0 moves and their direction
    always_comb begin
        cp0_op.rd_en = instr_valid && (opcode == OP_COP0) && !instr[23];
        cp0_op.wr_en = instr_valid && (opcode == OP_COP0) &&  instr[23];
        cp0_op.sel   = instr[15:11];
    end

endmodule

// File: rtl/exc_cause_sel.sv
// Module: exc_cause_sel
// Picks at most one exception source per instruction; a TLB miss wins
// over a trap. Assumes is_trap is already gated by instr_valid.
module exc_cause_sel
    import exc_pkg::*;
(
    input  logic   instr_valid,
    input  logic   is_trap,
    input  logic   tlb_miss,
    output logic   take,
    output cause_e cause
);

    // Fixed priority selection of the exception cause
    always_comb begin
        cause = CAUSE_NONE;
        if (instr_valid && tlb_miss) begin
            cause = CAUSE_TLB;
        end else if (is_trap) begin
            cause = CAUSE_TRAP;
        end
        take = (cause != CAUSE_NONE);
    end

endmodule

// File: rtl/exc_epc_calc.sv
// Module: exc_epc_calc
// Forms the return address to be saved: the word address of pc+4 with
// a delay-slot flag in bit 1 and a trap flag in bit 0.
// Assumes the instruction addresses are word aligned.
module exc_epc_calc #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] pc_next,
    input  logic            trap_flag,
    output logic [XLEN-1:0] epc_value
);

    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(4);

    logic [XLEN-1:0] pc_seq;
    logic            in_slot;
    logic            unused_low;

    assign unused_low = ^pc_seq[1:0];

    // Sequential successor and delay-slot detection
    always_comb begin
        pc_seq  = pc + WORD_STEP;
        in_slot = (pc_next != pc_seq);
    end

    // Pack the address with the two flags
    always_comb begin
        epc_value = {pc_seq[XLEN-1:2], in_slot, trap_flag};
    end

endmodule

// File: rtl/exc_cp0_regs.sv
// Module: exc_cp0_regs
// Holds the status bit, the user-mode flag and the saved return address.
// An exception has precedence over a move-to in the same cycle.
// Assumes wr_en is already gated by instr_valid.
module exc_cp0_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [XLEN-1:0] epc_value,
    input  logic            wr_en,
    input  logic [1:0]      wr_bits,
    input  logic            pid_nonzero,
    output logic            status_q,
    output logic            user_q,
    output logic [XLEN-1:0] epc_q
);

    // Register update: reset, exception entry, or move-to
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            user_q   <= 1'b0;
            epc_q    <= '0;
        end else if (take) begin
            epc_q  <= epc_value;
            user_q <= 1'b0;
        end else if (wr_en) begin
            status_q <= wr_bits[0];
            if (pid_nonzero && wr_bits[1]) begin
                user_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/exc_ctrl.sv
// Module: exc_ctrl (top)
// Exception entry and coprocessor-0 status control. It redirects the fetch
// to VECTOR, squashes the next instruction and cancels the rt write when an
// exception is taken, and it executes the coprocessor-0 moves.
// Assumes one instruction per cycle and word-aligned addresses.
module exc_ctrl #(
    parameter int               XLEN       = 32,
    parameter int               PID_W      = 8,
    parameter logic [XLEN-1:0]  VECTOR     = XLEN'(32'h3C),
    parameter logic [4:0]       STATUS_SEL = 5'd12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [31:0]         instr,
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     pc_next,
    input  logic                tlb_miss,
    input  logic [PID_W-1:0]    pid,
    input  logic [XLEN-1:0]     rt_val,
    output logic                redirect_valid,
    output logic [XLEN-1:0]     redirect_pc,
    output logic                squash_next,
    output logic                rt_write_cancel,
    output logic [XLEN-1:0]     cp0_rdata,
    output logic                status,
    output logic                user_mode,
    output logic [XLEN-1:0]     epc
);
    import exc_pkg::*;

    logic            is_trap;
    cp0_op_t         cp0_op;
    logic            take;
    cause_e          cause;
    logic [XLEN-1:0] epc_value;
    logic            pid_nonzero;
    logic            unused_rt;

    assign unused_rt   = ^rt_val[XLEN-1:2];
    assign pid_nonzero = |pid;

    exc_decode u_decode (
        .instr_valid (instr_valid),
        .instr       (instr),
        .is_trap     (is_trap),
        .cp0_op      (cp0_op)
    );

    exc_cause_sel u_cause (
        .instr_valid (instr_valid),
        .is_trap     (is_trap),
        .tlb_miss    (tlb_miss),
        .take        (take),
        .cause       (cause)
    );

    exc_epc_calc #(.XLEN(XLEN)) u_epc (
        .pc        (pc),
        .pc_next   (pc_next),
        .trap_flag (cause == CAUSE_TRAP),
        .epc_value (epc_value)
    );

    exc_cp0_regs #(.XLEN(XLEN)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .epc_value   (epc_value),
        .wr_en       (cp0_op.wr_en),
        .wr_bits     (rt_val[1:0]),
        .pid_nonzero (pid_nonzero),
        .status_q    (status),
        .user_q      (user_mode),
        .epc_q       (epc)
    );

    // Pipeline control outputs for a taken exception
    always_comb begin
        redirect_valid  = take;
        squash_next     = take;
        rt_write_cancel = take;
        redirect_pc     = VECTOR;
    end

    // Move-from read data selection
    always_comb begin
        cp0_rdata = '0;
        if (cp0_op.rd_en) begin
            if (cp0_op.sel == STATUS_SEL) begin
                cp0_rdata = {{(XLEN-1){1'b0}}, status};
            end else begin
                cp0_rdata = epc;
            end
        end
    end

endmodule

// Checker: temporal properties of exc_ctrl observed at its ports.
module exc_ctrl_chk #(
    parameter int XLEN  = 32,
    parameter int PID_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [XLEN-1:0]  pc,
    input logic [XLEN-1:0]  pc_next,
    input logic [PID_W-1:0] pid,
    input logic             redirect_valid,
    input logic             squash_next,
    input logic             rt_write_cancel,
    input logic             status,
    input logic             user_mode,
    input logic [XLEN-1:0]  epc
);

    logic [XLEN-1:0] pc_plus;
    assign pc_plus = pc + XLEN'(4);

    a_r2_flags_together: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (squash_next && rt_write_cancel));

    a_r10_idle_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !redirect_valid);

    a_r3_epc_address: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (epc[XLEN-1:2] == $past(pc_plus[XLEN-1:2])));

    a_r4_slot_flag: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (epc[1] == $past(pc_next != pc_plus)));

    a_r6_user_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !user_mode);

    a_r6_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> $stable(status));

    a_r9_no_user_pid0: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && (pid == '0) && !user_mode) |=> !user_mode);

    a_r10_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |=> $stable(epc));

endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .PID_W(PID_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .instr_valid     (instr_valid),
    .pc              (pc),
    .pc_next         (pc_next),
    .pid             (pid),
    .redirect_valid  (redirect_valid),
    .squash_next     (squash_next),
    .rt_write_cancel (rt_write_cancel),
    .status          (status),
    .user_mode       (user_mode),
    .epc             (epc)
);

// File: tb/exc_ctrl_tb.sv
// Directed bench for exc_ctrl: one task per scenario, each checking itself.
module exc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr;
    logic [31:0] pc;
    logic [31:0] pc_next;
    logic        tlb_miss;
    logic [7:0]  pid;
    logic [31:0] rt_val;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        squash_next;
    logic        rt_write_cancel;
    logic [31:0] cp0_rdata;
    logic        status;
    logic        user_mode;
    logic [31:0] epc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    exc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .pc(pc), .pc_next(pc_next), .tlb_miss(tlb_miss), .pid(pid),
        .rt_val(rt_val), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .squash_next(squash_next),
        .rt_write_cancel(rt_write_cancel), .cp0_rdata(cp0_rdata),
        .status(status), .user_mode(user_mode), .epc(epc)
    );

    function automatic logic [31:0] special(input logic [5:0] fn);
        return {6'h00, 20'h12345 & 20'hFFFFF, fn};
    endfunction

    function automatic logic [31:0] cop0(input logic to_cp0, input logic [4:0] rd);
        return {6'h10, 2'b00, to_cp0, 2'b00, 5'd3, rd, 11'd0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        instr_valid = 1'b0; instr = 32'h0; tlb_miss = 1'b0; rt_val = 32'h0;
    endtask

    // Present one instruction at the falling edge, let it settle
    task automatic present(input logic [31:0] i, input logic [31:0] p,
                           input logic [31:0] pn, input logic miss,
                           input logic [31:0] rv);
        @(negedge clk);
        instr_valid = 1'b1; instr = i; pc = p; pc_next = pn;
        tlb_miss = miss; rt_val = rv;
        #1;
    endtask

    task automatic commit();
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic check_flags(input logic exp_take, input string req);
        check(redirect_valid == exp_take, req, 32'(redirect_valid), 32'(exp_take));
        check(squash_next == exp_take && rt_write_cancel == exp_take, req,
              32'({squash_next, rt_write_cancel}), 32'({exp_take, exp_take}));
        if (exp_take) check(redirect_pc == 32'h3C, req, redirect_pc, 32'h3C);
    endtask

    task automatic t_reset();
        check(status == 1'b0, "R1 status", 32'(status), 32'h0);
        check(user_mode == 1'b0, "R1 user", 32'(user_mode), 32'h0);
        check(epc == 32'h0, "R1 epc", epc, 32'h0);
    endtask

    task automatic t_move_to();
        pid = 8'd0;
        present(cop0(1'b1, 5'd12), 32'h10, 32'h14, 1'b0, 32'h3);
        check_flags(1'b0, "R8 no exception");
        commit();
        check(status == 1'b1, "R8 status load", 32'(status), 32'h1);
        check(user_mode == 1'b0, "R9 pid zero refuses", 32'(user_mode), 32'h0);
        pid = 8'd5;
        present(cop0(1'b1, 5'd12), 32'h14, 32'h18, 1'b0, 32'h2);
        commit();
        check(status == 1'b0, "R8 status clear", 32'(status), 32'h0);
        check(user_mode == 1'b1, "R9 user set", 32'(user_mode), 32'h1);
        present(cop0(1'b1, 5'd12), 32'h18, 32'h1C, 1'b0, 32'h1);
        commit();
        check(user_mode == 1'b1, "R9 bit1 zero keeps", 32'(user_mode), 32'h1);
        present(cop0(1'b0, 5'd12), 32'h1C, 32'h20, 1'b0, 32'h0);
        check(cp0_rdata == 32'h1, "R7 read status", cp0_rdata, 32'h1);
        commit();
    endtask

    task automatic t_syscall();
        present(special(6'h0C), 32'h100, 32'h104, 1'b0, 32'h0);
        check_flags(1'b1, "R2 syscall");
        commit();
        check(epc == 32'h105, "R3 R5 syscall epc", epc, 32'h105);
        check(user_mode == 1'b0, "R6 user cleared", 32'(user_mode), 32'h0);
        check(status == 1'b1, "R6 status kept", 32'(status), 32'h1);
        present(cop0(1'b0, 5'd14), 32'h3C, 32'h40, 1'b0, 32'h0);
        check(cp0_rdata == 32'h105, "R7 read epc", cp0_rdata, 32'h105);
        commit();
    endtask

    task automatic t_break_slot();
        present(special(6'h0D), 32'h200, 32'h400, 1'b0, 32'h0);
        check_flags(1'b1, "R2 break");
        commit();
        check(epc == 32'h207, "R4 delay slot break", epc, 32'h207);
    endtask

    task automatic t_tlb();
        present(32'h8C41_0000, 32'h300, 32'h304, 1'b1, 32'h0);
        check_flags(1'b1, "R2 tlb miss");
        commit();
        check(epc == 32'h304, "R5 tlb no trap flag", epc, 32'h304);
        present(special(6'h0C), 32'h40, 32'h80, 1'b1, 32'h0);
        commit();
        check(epc == 32'h46, "R5 tlb priority", epc, 32'h46);
    endtask

    task automatic t_invalid();
        @(negedge clk);
        instr_valid = 1'b0; instr = special(6'h0D); pc = 32'h500;
        pc_next = 32'h504; tlb_miss = 1'b1; rt_val = 32'h0;
        #1;
        check_flags(1'b0, "R10 invalid ignored");
        commit();
        check(epc == 32'h46, "R10 epc unchanged", epc, 32'h46);
        check(status == 1'b1, "R10 status unchanged", 32'(status), 32'h1);
    endtask

    task automatic t_move_with_miss();
        present(cop0(1'b1, 5'd12), 32'h600, 32'h604, 1'b1, 32'h0);
        check_flags(1'b1, "R11 miss with move-to");
        commit();
        check(status == 1'b1, "R11 move-to suppressed", 32'(status), 32'h1);
        check(epc == 32'h604, "R11 epc captured", epc, 32'h604);
    endtask

    task automatic t_plain();
        present(32'h0043_0820, 32'h700, 32'h704, 1'b0, 32'h3);
        check_flags(1'b0, "R12 plain instruction");
        check(cp0_rdata == 32'h0, "R12 no read data", cp0_rdata, 32'h0);
        commit();
        check(status == 1'b1 && user_mode == 1'b0, "R12 state kept",
              32'({status, user_mode}), 32'h2);
        check(epc == 32'h604, "R12 epc kept", epc, 32'h604);
    endtask

    initial begin
        rst_n = 1'b0; pid = 8'd0; pc = 32'h0; pc_next = 32'h4;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        check_flags(1'b0, "R1 idle after reset");
        t_move_to();
        t_syscall();
        t_break_slot();
        t_tlb();
        t_invalid();
        t_move_with_miss();
        t_plain();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule